// File: doc/BRIEF.md
# Infrared Command Packet Transmitter

This block drives an infrared LED with a remote-control command packet that repeats at a fixed rate. Every packet opens with a start burst and a vehicle-select burst. One burst follows for each of four direction buttons: right, left, forward and backward. A silent gap comes after each burst. Every burst is a train of carrier pulses, and the LED is never held steadily on. A direction burst carries its button's state in its length. It is long when the button is pressed and short when it is not.

Everything runs on the system clock and is paced by single-cycle enable strobes. A packet timer raises a start request once per packet interval. A carrier counter marks the carrier periods. A sequencer steps through the fields and counts each field's length in whole carrier periods. The button levels are captured once, as a packet starts, so every packet describes one consistent moment. When a packet is longer than the packet interval, the request that arrives during it is held. That packet then starts as soon as the current one has finished.

Top module: `ir_cmd_tx`

## Requirements
- R1: When a packet fits inside the interval, packet starts (the first carrier pulse of the start burst) are exactly PKT_CLKS clocks apart.
- R2: During a burst the output is a pulse train. Each pulse is high for CAR_CLKS/2 clocks and low for the rest of a CAR_CLKS-clock period, so no high run ever lasts longer than CAR_CLKS/2 clocks.
- R3: The first burst of a packet holds LEN_START carrier pulses and the second holds LEN_SEL pulses.
- R4: Bursts three to six stand for the buttons right, left, forward and backward, in that order. Each holds LEN_LONG pulses when its button is 1 and LEN_SHORT pulses when it is 0.
- R5: Between consecutive bursts the output stays low for LEN_GAP full carrier periods. Together with the low half of the last pulse, this gives a low run of (CAR_CLKS - CAR_CLKS/2) + LEN_GAP*CAR_CLKS clocks.
- R6: The button levels are captured as a packet starts. A change during the packet has no effect on that packet.
- R7: When a packet request arrives while a packet is still being sent, the next packet starts one clock after the final gap ends. Several requests that arrive during one packet start only one packet.
- R8: While reset is asserted, and from reset until the first packet starts, the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_right | input | 1 | Right button level, 1 = pressed |
| btn_left | input | 1 | Left button level, 1 = pressed |
| btn_fwd | input | 1 | Forward button level, 1 = pressed |
| btn_back | input | 1 | Backward button level, 1 = pressed |
| ir_led | output | 1 | LED drive, modulated during bursts |

## Verification
The bench builds the main instance with a 1000-clock packet interval and a 10-clock carrier. Its field lengths are 3, 2, 5 and 1 carrier periods for start, select, long and short, with 2-period gaps. This shrinks a packet to a few hundred clocks, so every pulse, gap and packet interval can be counted exactly across several button patterns. A second instance uses a 200-clock interval with all buttons pressed. Its 370-clock packets overrun the interval, which exercises the held request and the one-clock restart.

// File: rtl/irtx_pkg.sv
package irtx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic right;
        logic left;
        logic fwd;
        logic back;
    } btn_set_t;

    localparam int unsigned NUM_BURSTS = 6;
    localparam int unsigned IDX_W      = 3;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Burst length in carrier periods for burst slot idx
    function automatic int unsigned burst_periods(
        logic [IDX_W-1:0] idx, btn_set_t b,
        int unsigned l_start, int unsigned l_sel,
        int unsigned l_long, int unsigned l_short);
        case (idx)
            3'd0:    return l_start;
            3'd1:    return l_sel;
            3'd2:    return b.right ? l_long : l_short;
            3'd3:    return b.left  ? l_long : l_short;
            3'd4:    return b.fwd   ? l_long : l_short;
            default: return b.back  ? l_long : l_short;
        endcase
    endfunction

endpackage

// File: rtl/irtx_pkt_timer.sv
module irtx_pkt_timer #(
    parameter int unsigned PKT_CLKS = 10_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned TW = $clog2(PKT_CLKS);

    logic [TW-1:0] cnt;

    assign tick = (cnt == TW'(PKT_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || tick) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier #(
    parameter int unsigned CAR_CLKS = 2778
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic carrier_hi,
    output logic period_end
);
    localparam int unsigned CW   = $clog2(CAR_CLKS);
    localparam int unsigned HALF = CAR_CLKS / 2;

    logic [CW-1:0] cnt;

    assign carrier_hi = (cnt < CW'(HALF));
    assign period_end = run && (cnt == CW'(CAR_CLKS - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || period_end) cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/irtx_sequencer.sv
module irtx_sequencer
    import irtx_pkg::*;
#(
    parameter int unsigned LEN_START = 192,
    parameter int unsigned LEN_GAP   = 25,
    parameter int unsigned LEN_SEL   = 44,
    parameter int unsigned LEN_LONG  = 88,
    parameter int unsigned LEN_SHORT = 22
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  btn_set_t btn_in,
    input  logic     period_end,
    output logic     running,
    output logic     burst_on,
    output logic     pend_o,
    output logic     start_o,
    output btn_set_t btn_q_o
);
    localparam int unsigned MAX_LEN = max2(max2(max2(LEN_START, LEN_GAP),
                                                max2(LEN_SEL, LEN_LONG)), LEN_SHORT);
    localparam int unsigned LW = $clog2(MAX_LEN + 1);

    seq_state_e       state;
    logic [IDX_W-1:0] fidx;
    logic [LW-1:0]    pcnt;
    logic             pend;
    btn_set_t         btn_q;
    logic             start;
    int unsigned      field_len;
    logic             field_done;

    assign start      = (state == ST_IDLE) && (tick || pend);
    assign field_len  = (state == ST_GAP) ? LEN_GAP :
                        burst_periods(fidx, btn_q, LEN_START, LEN_SEL, LEN_LONG, LEN_SHORT);
    assign field_done = period_end && (pcnt == LW'(field_len - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            fidx  <= '0;
            pcnt  <= '0;
            pend  <= 1'b0;
            btn_q <= '0;
        end else begin
            if (start)     pend <= 1'b0;
            else if (tick) pend <= 1'b1;

            if (start) begin
                state <= ST_BURST;
                fidx  <= '0;
                pcnt  <= '0;
                btn_q <= btn_in;
            end else if (field_done) begin
                pcnt <= '0;
                if (state == ST_BURST) begin
                    state <= ST_GAP;
                end else if (fidx == IDX_W'(NUM_BURSTS - 1)) begin
                    state <= ST_IDLE;
                end else begin
                    state <= ST_BURST;
                    fidx  <= fidx + 1'b1;
                end
            end else if (period_end) begin
                pcnt <= pcnt + 1'b1;
            end
        end
    end

    assign running  = (state != ST_IDLE);
    assign burst_on = (state == ST_BURST);
    assign pend_o   = pend;
    assign start_o  = start;
    assign btn_q_o  = btn_q;
endmodule

// File: rtl/ir_cmd_tx.sv
module ir_cmd_tx
    import irtx_pkg::*;
#(
    parameter int unsigned PKT_CLKS  = 10_000_000,
    parameter int unsigned CAR_CLKS  = 2778,
    parameter int unsigned LEN_START = 192,
    parameter int unsigned LEN_GAP   = 25,
    parameter int unsigned LEN_SEL   = 44,
    parameter int unsigned LEN_LONG  = 88,
    parameter int unsigned LEN_SHORT = 22
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_right,
    input  logic btn_left,
    input  logic btn_fwd,
    input  logic btn_back,
    output logic ir_led
);
    logic     tick;
    logic     carrier_hi;
    logic     period_end;
    logic     running;
    logic     burst_on;
    logic     seq_pend;
    logic     seq_start;
    btn_set_t btn_now;
    btn_set_t btn_held;

    assign btn_now = '{right: btn_right, left: btn_left, fwd: btn_fwd, back: btn_back};

    irtx_pkt_timer #(.PKT_CLKS(PKT_CLKS)) u_timer (
        .clk(clk), .rst(rst), .tick(tick)
    );

    irtx_carrier #(.CAR_CLKS(CAR_CLKS)) u_carrier (
        .clk(clk), .rst(rst), .run(running),
        .carrier_hi(carrier_hi), .period_end(period_end)
    );

    irtx_sequencer #(
        .LEN_START(LEN_START), .LEN_GAP(LEN_GAP), .LEN_SEL(LEN_SEL),
        .LEN_LONG(LEN_LONG), .LEN_SHORT(LEN_SHORT)
    ) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .btn_in(btn_now),
        .period_end(period_end), .running(running), .burst_on(burst_on),
        .pend_o(seq_pend), .start_o(seq_start), .btn_q_o(btn_held)
    );

    assign ir_led = burst_on && carrier_hi;
endmodule

// File: rtl/irtx_checker.sv
module irtx_checker
    import irtx_pkg::*;
#(
    parameter int unsigned CAR_CLKS = 2778
) (
    input logic     clk,
    input logic     rst,
    input logic     ir_led,
    input logic     running,
    input logic     burst_on,
    input logic     pend,
    input logic     start,
    input btn_set_t btn_held
);
    localparam int unsigned HALF = CAR_CLKS / 2;

    int unsigned hi_run;

    always_ff @(posedge clk) begin
        if (rst)         hi_run <= 0;
        else if (ir_led) hi_run <= hi_run + 1;
        else             hi_run <= 0;
    end

    // R2: no high run is longer than half a carrier period
    a_r2_pulse_width: assert property (@(posedge clk) disable iff (rst)
        ir_led |-> (hi_run < HALF));

    // R5: output low whenever no burst is in progress
    a_r5_gap_low: assert property (@(posedge clk) disable iff (rst)
        !burst_on |-> !ir_led);

    // R6: captured buttons stay put unless a packet starts
    a_r6_btn_held: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(btn_held));

    // R7: a held request in idle launches a packet on the next clock
    a_r7_pending_start: assert property (@(posedge clk) disable iff (rst)
        (!running && pend) |=> running);

    // R8: reset leaves the output low and the sequencer idle
    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> (!ir_led && !running));
endmodule

bind ir_cmd_tx irtx_checker #(.CAR_CLKS(CAR_CLKS)) u_chk (
    .clk(clk), .rst(rst), .ir_led(ir_led), .running(running),
    .burst_on(burst_on), .pend(seq_pend), .start(seq_start),
    .btn_held(btn_held)
);

// File: tb/ir_cmd_tx_bench.sv
`timescale 1ns/1ps
module ir_cmd_tx_bench;
    localparam int PKT   = 1000;
    localparam int PKT_O = 200;
    localparam int CAR   = 10;
    localparam int HALF  = CAR / 2;
    localparam int L_ST  = 3;
    localparam int L_GAP = 2;
    localparam int L_SEL = 2;
    localparam int L_LNG = 5;
    localparam int L_SHT = 1;
    localparam int GAPRUN = (CAR - HALF) + L_GAP * CAR;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic b_r = 1'b0, b_l = 1'b0, b_f = 1'b0, b_b = 1'b0;
    logic led, led_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ir_cmd_tx #(.PKT_CLKS(PKT), .CAR_CLKS(CAR), .LEN_START(L_ST), .LEN_GAP(L_GAP),
                .LEN_SEL(L_SEL), .LEN_LONG(L_LNG), .LEN_SHORT(L_SHT)) u_ir_cmd_tx (
        .clk(clk), .rst(rst), .btn_right(b_r), .btn_left(b_l),
        .btn_fwd(b_f), .btn_back(b_b), .ir_led(led));

    ir_cmd_tx #(.PKT_CLKS(PKT_O), .CAR_CLKS(CAR), .LEN_START(L_ST), .LEN_GAP(L_GAP),
                .LEN_SEL(L_SEL), .LEN_LONG(L_LNG), .LEN_SHORT(L_SHT)) u_ir_cmd_tx_ovr (
        .clk(clk), .rst(rst), .btn_right(1'b1), .btn_left(1'b1),
        .btn_fwd(1'b1), .btn_back(1'b1), .ir_led(led_o));

    // packet start logs: rising edge after a long low run
    int st_m[32];
    int n_m = 0;
    int st_o[32];
    int n_o = 0;
    int low_m = 1000, low_o = 1000;

    always @(negedge clk) begin
        if (!rst) begin
            if (led && low_m > GAPRUN && n_m < 32) begin st_m[n_m] = cyc; n_m++; end
            if (led_o && low_o > GAPRUN && n_o < 32) begin st_o[n_o] = cyc; n_o++; end
            low_m = led ? 0 : low_m + 1;
            low_o = led_o ? 0 : low_o + 1;
        end
    end

    task automatic check(string req, int act, int exp, string what);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    int np[6];
    int gl[6];
    int bad_hi;

    // decode one packet from the main instance; optionally flip buttons after start
    task automatic decode_pkt(bit do_flip, logic [3:0] flip_to);
        int h, l;
        bad_hi = 0;
        do @(negedge clk); while (!led);
        if (do_flip) {b_r, b_l, b_f, b_b} = flip_to;
        for (int b = 0; b < 6; b++) begin
            np[b] = 0;
            forever begin
                h = 0;
                while (led) begin h++; @(negedge clk); end
                if (h != HALF) bad_hi++;
                np[b]++;
                l = 0;
                while (!led && l <= GAPRUN) begin l++; @(negedge clk); end
                if (!(led && l == CAR - HALF)) break;
            end
            gl[b] = l;
        end
    endtask

    task automatic t_reset();
        bit hi = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (led) hi = 1; end
        check("R8", hi, 0, "output during reset");
        rst = 1'b0;
        for (int i = 0; i < PKT - 50; i++) begin @(negedge clk); if (led) hi = 1; end
        check("R8", hi, 0, "output before first packet");
    endtask

    task automatic t_pattern(logic [3:0] btns, bit flip);
        int exp_d;
        {b_r, b_l, b_f, b_b} = btns;
        decode_pkt(flip, ~btns);
        check("R3", np[0], L_ST, "start burst pulses");
        check("R3", np[1], L_SEL, "select burst pulses");
        for (int d = 0; d < 4; d++) begin
            exp_d = btns[3-d] ? L_LNG : L_SHT;
            check(flip ? "R6" : "R4", np[2+d], exp_d, $sformatf("direction %0d pulses", d));
        end
        for (int g = 0; g < 5; g++) check("R5", gl[g], GAPRUN, $sformatf("gap %0d low run", g));
        check("R5", gl[5], GAPRUN + 1, "low after last burst");
        check("R2", bad_hi, 0, "pulses with wrong high width");
    endtask

    task automatic t_interval();
        check("R1", n_m >= 3 ? 1 : 0, 1, "packets seen");
        for (int i = 1; i < n_m; i++) check("R1", st_m[i] - st_m[i-1], PKT, "packet interval");
    endtask

    task automatic t_overrun();
        int len = (L_ST + L_SEL + 4 * L_LNG + 6 * L_GAP) * CAR;
        check("R7", n_o >= 3 ? 1 : 0, 1, "overrun packets seen");
        for (int i = 1; i < n_o; i++) check("R7", st_o[i] - st_o[i-1], len + 1, "overrun interval");
    endtask

    initial begin
        t_reset();
        t_pattern(4'b0000, 1'b0);
        t_pattern(4'b1111, 1'b0);
        t_pattern(4'b1010, 1'b0);
        t_pattern(4'b0101, 1'b0);
        t_pattern(4'b0011, 1'b1);
        t_interval();
        t_overrun();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule